// File: doc/BRIEF.md
# Flow-Through Burst SRAM Access Controller

This block is the cycle-decode and control core of a synchronous burst SRAM whose read path is flow-through. The word is 36 bits wide, split into four 9-bit byte lanes. On every rising clock edge it samples three chip-select inputs, a processor address strobe, a controller address strobe, an advance input and the write controls. From these it classifies the cycle as one of five kinds: deselect, new read, new write, burst continue or burst suspend. It then presents the array address, one write strobe per lane, and a data-output enable. A small behavioural lane array is built in, so the read path can be observed at the ports.

An access starts when the chip selects are active and an address strobe is accepted. The two strobes follow different rules. The processor strobe has priority but always opens a read. The controller strobe can open either a read or a write. After the start, a two-bit wraparound counter walks the burst in linear or interleaved order while advance is held low. The data-output enable combines the asynchronous output-enable pin with three masking rules: write cycles, the first read after a deselect, and reads that continue a burst after a write.

All pins are plain level-sampled control and data. The SRAM protocol has no back-pressure, so there is no valid/ready pair. Every cycle is accepted and every result is due in a fixed cycle.

Top module: `fts_burst_ctrl`

## Requirements
- R1: A new access starts only when ce1_n=0, ce2=1 and ce3_n=0 and an accepted strobe is low. A strobe seen with the selects inactive is a deselect: lane_we=0, dq_oe=0, and the burst ends.
- R2: When both strobes are low, the processor strobe wins. While ce1_n=1 the processor strobe is ignored: with adsc_n=0 the cycle is a deselect, and with adsc_n=1 it is a burst continue or suspend.
- R3: A cycle opened by the processor strobe is a read, with lane_we=0, whatever gw_n, bwe_n and bw_n show.
- R4: Write lane decode:
  - A write is requested when gw_n=0, or when bwe_n=0 and some bw_n bit is 0.
  - With gw_n=0, lane_we is 4'b1111.
  - Otherwise, lane_we[i] = !bw_n[i].
  - lane_we bit i writes wdata[9i+8:9i].
  - A controller-strobe start with a write request is a write at addr.
- R5: The burst counter starts at 0 on each strobe start and advances by one, wrapping, on each continue cycle (adv_n=0).
  - With seq_ilv=1, the two low address bits are the start bits XOR the count.
  - With seq_ilv=0, they are the start bits plus the count, modulo 4.
  - The upper address bits hold for the whole burst.
- R6: A suspend cycle (no strobe, adv_n=1) keeps the address unchanged. In continue and suspend cycles the chip selects are not sampled. Such a cycle is a write if a write is requested, and a read otherwise.
- R7: A deselect ends the burst. After it, cycles without a strobe are idle (lane_we=0, dq_oe=0), whatever adv_n and the write inputs show.
- R8: Reads are flow-through. During the cycle after the edge that registers a read address, rd_data is the stored word at mem_addr. dq_oe is 1 only in read cycles with oe_n=0, unless masked by R9, R10 or R11.
- R9: In a write cycle dq_oe is 0 regardless of oe_n.
- R10: In the first read cycle that follows an idle or deselect cycle, dq_oe is 0.
- R11: After a write cycle, read cycles reached by continue or suspend keep dq_oe at 0 until a strobe starts a new access.
- R12: Write data and lanes are registered at the edge and reach the array at the following edge. A read of that word one cycle later returns the new lanes, with unwritten lanes unchanged.
- R13: While rst_n is low and directly after it, the block is idle: lane_we=0, dq_oe=0, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Chip select, active low. Also gates the processor strobe |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write: all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| mem_addr | output | ADDR_W | Array address of the current cycle |
| lane_we | output | LANES | Per-lane write strobes of the current cycle |
| dq_oe | output | 1 | Data-output enable |
| rd_data | output | LANES*LANE_W | Array word at mem_addr |

## Verification
Each input is sampled at one rising edge. mem_addr, lane_we and rd_data take their new values right after that edge, and dq_oe also follows oe_n within the cycle. A write takes effect one edge later, so it shows in rd_data when the same word is read one cycle after the write. The bench steps a behavioural model at each edge, including that one-edge write delay. It samples all four outputs 5 ns after the edge, while inputs stay steady, and compares every cycle. Each phase carries the requirement tag it targets.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/fts_cycle_decode.sv
module fts_cycle_decode
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             active_q,
  output op_e              op_nxt,
  output logic             load,
  output logic             advance,
  output logic             active_nxt,
  output logic [LANES-1:0] lanes_nxt
);
  logic sel, p_take, strobe, wr_req;

  assign sel    = !ce1_n && ce2 && !ce3_n;
  assign p_take = !adsp_n && !ce1_n;
  assign strobe = p_take || !adsc_n;
  assign wr_req = !gw_n || (!bwe_n && (bw_n != {LANES{1'b1}}));

  always_comb begin
    lanes_nxt = '0;
    if (!gw_n)       lanes_nxt = {LANES{1'b1}};
    else if (!bwe_n) lanes_nxt = ~bw_n;
  end

  always_comb begin
    op_nxt     = OP_IDLE;
    load       = 1'b0;
    advance    = 1'b0;
    active_nxt = active_q;
    if (strobe) begin
      if (sel) begin
        load       = 1'b1;
        active_nxt = 1'b1;
        op_nxt     = (p_take || !wr_req) ? OP_RD : OP_WR;
      end else begin
        active_nxt = 1'b0;
      end
    end else if (active_q) begin
      advance = !adv_n;
      op_nxt  = wr_req ? OP_WR : OP_RD;
    end
  end

  p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n) |-> (op_nxt != OP_WR));
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ce2 && !ce3_n) && !adsc_n) |-> (op_nxt == OP_IDLE && !active_nxt));
  p_gw_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && op_nxt == OP_WR) |-> (lanes_nxt == {LANES{1'b1}}));
endmodule

// File: rtl/fts_burst_addr.sv
module fts_burst_addr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              seq_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (advance) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  generate
    if (HI_W > 0) begin : g_ok
      assign low      = seq_ilv ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
      assign mem_addr = {base_q[ADDR_W-1:2], low};
    end
  endgenerate

  p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));
  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> (mem_addr == $past(mem_addr)));
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
        if (lane_we[g]) store[addr] <= wr_data[g*LANE_W +: LANE_W];
      end
      assign rd_data[g*LANE_W +: LANE_W] = store[addr];
    end
  endgenerate
endmodule

// File: rtl/fts_burst_ctrl.sv
module fts_burst_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    seq_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic [LANES-1:0]        lane_we,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op_q, op_nxt;
  logic              active_q, active_nxt, load, advance;
  logic              mask_q, wrlock_q;
  logic [LANES-1:0]  lanes_nxt, lanes_q;
  logic [DATA_W-1:0] wdata_q;

  fts_cycle_decode #(.LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .active_q(active_q), .op_nxt(op_nxt),
    .load(load), .advance(advance), .active_nxt(active_nxt),
    .lanes_nxt(lanes_nxt)
  );

  fts_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .seq_ilv(seq_ilv), .addr_in(addr), .mem_addr(mem_addr)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(mem_addr), .lane_we(lane_we), .wr_data(wdata_q),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      active_q <= 1'b0;
      mask_q   <= 1'b0;
      wrlock_q <= 1'b0;
      lanes_q  <= '0;
      wdata_q  <= '0;
    end else begin
      op_q     <= op_nxt;
      active_q <= active_nxt;
      mask_q   <= load && (op_nxt == OP_RD) && (op_q == OP_IDLE);
      lanes_q  <= (op_nxt == OP_WR) ? lanes_nxt : '0;
      wdata_q  <= wdata;
      if (op_nxt == OP_WR) wrlock_q <= 1'b1;
      else if (load)       wrlock_q <= 1'b0;
    end
  end

  assign lane_we = lanes_q;
  assign dq_oe   = (op_q == OP_RD) && !oe_n && !mask_q && !wrlock_q;

  p_wr_blocks_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !dq_oe);
  p_first_rd_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_q) == OP_IDLE && op_q == OP_RD) |-> !dq_oe);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE) |-> (lane_we == '0 && !dq_oe));
endmodule

// File: tb/sim_fts_burst_ctrl.sv
module sim_fts_burst_ctrl;
  localparam int AW = 6, NL = 4, LW = 9, DW = NL * LW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, seq_ilv;
  logic [NL-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] rd_data;
  logic [NL-1:0] lane_we;
  logic dq_oe;

  always #10 clk = ~clk;

  fts_burst_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .seq_ilv(seq_ilv),
    .addr(addr), .wdata(wdata), .mem_addr(mem_addr), .rd_data(rd_data),
    .lane_we(lane_we), .dq_oe(dq_oe)
  );

  int errors = 0, checks = 0;
  string cur = "R13";

  // behavioural reference state
  logic [DW-1:0] mem [DEPTH];
  int  m_op = 0, m_base = 0, m_cnt = 0, m_addr = 0;
  bit  m_active = 0, m_mask = 0, m_lock = 0;
  logic [NL-1:0] m_lanes = '0;
  logic [DW-1:0] m_wd = '0;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int cur_addr();
    int lo;
    lo = seq_ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) & 3);
    return (m_base & ~3) | lo;
  endfunction

  task automatic model_step();
    bit sel, ptake, wreq, was_idle;
    if (m_op == 2)
      for (int i = 0; i < NL; i++)
        if (m_lanes[i]) mem[m_addr][i*LW +: LW] = m_wd[i*LW +: LW];
    sel = !ce1_n && ce2 && !ce3_n;
    ptake = !adsp_n && !ce1_n;
    wreq = !gw_n || (!bwe_n && bw_n != '1);
    was_idle = (m_op == 0);
    m_mask = 0;
    if (ptake || !adsc_n) begin
      if (sel) begin
        m_active = 1; m_base = int'(addr); m_cnt = 0;
        m_op = (ptake || !wreq) ? 1 : 2;
        m_lock = 0;
        m_mask = was_idle && m_op == 1;
      end else begin
        m_active = 0; m_op = 0;
      end
    end else if (m_active) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      m_op = wreq ? 2 : 1;
    end else m_op = 0;
    m_lanes = '0;
    if (m_op == 2) begin
      m_lock = 1;
      m_lanes = !gw_n ? '1 : ~bw_n;
      m_wd = wdata;
    end
    m_addr = cur_addr();
  endtask

  task automatic compare();
    logic exp_oe;
    exp_oe = (m_op == 1) && !oe_n && !m_mask && !m_lock;
    check(cur, "dq_oe", DW'(dq_oe), DW'(exp_oe));
    check(cur, "lane_we", DW'(lane_we), DW'(m_lanes));
    if (m_op != 0) check(cur, "mem_addr", DW'(mem_addr), DW'(m_addr));
    if (m_op == 1) check(cur, "rd_data", rd_data, mem[m_addr]);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk); #5;
    compare();
    @(negedge clk);
  endtask

  task automatic quiet();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    quiet(); seq_ilv = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", "dq_oe", DW'(dq_oe), '0);
    check("R13", "lane_we", DW'(lane_we), '0);
    rst_n = 1;
    cur = "R13"; tick();

    // R4/R9: fill every word by controller-strobe global writes, oe_n low
    cur = "R9";
    for (int i = 0; i < DEPTH; i++) begin
      quiet(); adsc_n = 0; gw_n = 0; addr = AW'(i);
      wdata = DW'(i * 36'h1_0203 + 36'hA5A5);
      tick();
    end

    // R3: processor strobe with write inputs active is a read
    cur = "R3"; quiet(); adsp_n = 0; gw_n = 0; bwe_n = 0; bw_n = '0; addr = 6'd5; tick();

    // R5: linear burst from low bits 01, with wrap
    cur = "R5"; quiet(); seq_ilv = 0; adsc_n = 0; addr = 6'h15; tick();
    for (int i = 0; i < 5; i++) begin quiet(); adv_n = 0; tick(); end
    // R5: interleaved burst from low bits 01
    quiet(); seq_ilv = 1; adsp_n = 0; addr = 6'h25; tick();
    for (int i = 0; i < 4; i++) begin quiet(); adv_n = 0; tick(); end
    // R6: suspend, and selects not sampled during the burst
    cur = "R6"; quiet(); ce2 = 0; ce1_n = 1; tick();
    quiet(); ce3_n = 1; adv_n = 0; tick();
    quiet(); tick();

    // R2: both strobes with write request -> read; ce1_n high ignores adsp_n
    cur = "R2"; quiet(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 6'd9; tick();
    quiet(); ce1_n = 1; adsp_n = 0; adv_n = 0; tick();
    quiet(); ce1_n = 1; adsp_n = 0; adsc_n = 0; addr = 6'd3; tick();

    // R1/R7: deselect by chip selects, then advance has no effect
    cur = "R1"; quiet(); adsc_n = 0; addr = 6'd12; tick();
    quiet(); ce2 = 0; adsc_n = 0; tick();
    cur = "R7"; quiet(); adv_n = 0; gw_n = 0; tick();
    quiet(); adv_n = 0; tick();

    // R10: first read after idle is masked, then suspend shows data
    cur = "R10"; quiet(); adsp_n = 0; addr = 6'd20; tick();
    quiet(); tick();

    // R4/R12: byte write of lanes 0 and 2, then read back
    cur = "R12"; quiet(); adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 6'd33;
    wdata = 36'hF_0F0F_0F0F; tick();
    quiet(); adsc_n = 0; addr = 6'd33; tick();

    // R11: write continue after processor start, then reads stay disabled
    cur = "R11"; quiet(); adsp_n = 0; seq_ilv = 0; addr = 6'd8; tick();
    quiet(); adv_n = 0; gw_n = 0; wdata = 36'h1_2345_6789; tick();
    quiet(); adv_n = 0; tick();
    quiet(); tick();
    quiet(); adsc_n = 0; addr = 6'd9; tick();
    quiet(); tick();
    cur = "R8"; quiet(); oe_n = 1; tick();
    quiet(); adsp_n = 0; addr = 6'd40; tick();
    quiet(); adsp_n = 0; addr = 6'd41; tick();

    quiet(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule